// File: doc/BRIEF.md
# Sixteen-Bit ALU with Status and Control Flag Register

This block combines a 16-bit arithmetic/logic unit with a flags register. The unit can add, subtract, AND, OR or XOR two operands. The result comes out combinationally. In the same cycle the unit works out six status bits: carry, overflow, sign, zero, nibble carry and low-byte parity.

When the write strobe is high, the status bits are captured into a registered 16-bit flags word on the rising clock edge. Three control bits (step-trap, interrupt enable and direction) sit in the same word. They change only through dedicated set and clear strobes; they have no effect on the arithmetic.

Top module: `flag_alu16`

## Requirements
- R1: While reset is low and after it, until the first write or strobe, the flags word reads 0x0002.
- R2: The result is combinational and depends on the operation code: 0 = add, 1 = subtract (A minus B), 2 = AND, 3 = OR, 4 = XOR.
- R3: Carry (bit 0) shows an unsigned carry out of bit 15 on add, and a borrow (A < B unsigned) on subtract. The logic operations clear it.
- R4: Overflow (bit 11) is set when the signed add or subtract result falls outside -32768..32767. The logic operations clear it.
- R5: Sign (bit 7) copies bit 15 of the result. Zero (bit 6) is set when the result is 0.
- R6: Nibble carry (bit 4) shows a carry out of bit 3 on add, or a borrow from bit 4 on subtract (A[3:0] < B[3:0]). The logic operations leave it 0.
- R7: Parity (bit 2) is 1 when the low 8 result bits hold an even number of ones.
- R8: The status bits are loaded on the rising edge at which the write strobe is high, and hold otherwise. Bit 1 always reads 1. Bits 3, 5 and 12..15 always read 0.
- R9: The control bits are step-trap (bit 8), interrupt enable (bit 9) and direction (bit 10). They are set by strobe bits set[0..2] and cleared by clr[0..2], in that order. When both strobes are high, set wins. Writes of status bits never change the control bits.
- R10: Operation codes 5, 6 and 7 give a result of 0 and leave the status bits unchanged, even when the write strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 16 | Operand A |
| op_b | input | 16 | Operand B |
| op_sel | input | 3 | Operation code |
| wr_en | input | 1 | Load status bits at this edge |
| ctl_set | input | 3 | Set strobes for trap, interrupt, direction |
| ctl_clr | input | 3 | Clear strobes for trap, interrupt, direction |
| result | output | 16 | Combinational result |
| flags | output | 16 | Registered flags word |

## Verification
The result has no register in its path. It is due in the same cycle as its operands, so the bench checks it 1 ns after driving the inputs on the falling edge.

The flags word is one register stage behind. The bench checks it on the next falling edge, after exactly one rising edge. At that point it drops the write and strobe inputs, so that the next check sees only the new stimulus.

// File: rtl/flag_alu16.sv
module flag_alu16 #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [2:0]   op_sel,
  input  logic         wr_en,
  input  logic [2:0]   ctl_set,
  input  logic [2:0]   ctl_clr,
  output logic [W-1:0] result,
  output logic [15:0]  flags
);
  localparam int CB = 0, PB = 2, AB = 4, ZB = 6, SB = 7, TB = 8, OB = 11;

  logic [W:0]   ext;
  logic         is_arith, is_sub, op_ok;
  logic         c_n, o_n, a_n;
  logic         c_q, p_q, a_q, z_q, s_q, o_q;
  logic [2:0]   ctl_q;

  assign is_sub   = (op_sel == 3'd1);
  assign is_arith = (op_sel == 3'd0) || is_sub;
  assign op_ok    = (op_sel <= 3'd4);

  always_comb begin
    ext = '0;
    case (op_sel)
      3'd0:    ext = {1'b0, op_a} + {1'b0, op_b};
      3'd1:    ext = {1'b0, op_a} - {1'b0, op_b};
      3'd2:    ext = {1'b0, op_a & op_b};
      3'd3:    ext = {1'b0, op_a | op_b};
      3'd4:    ext = {1'b0, op_a ^ op_b};
      default: ext = '0;
    endcase
  end

  assign result = ext[W-1:0];
  assign c_n = is_arith & ext[W];
  assign a_n = is_arith & (op_a[4] ^ op_b[4] ^ ext[4]);
  assign o_n = is_arith & (is_sub ? ((op_a[W-1] ^ op_b[W-1]) & (op_a[W-1] ^ ext[W-1]))
                                  : (~(op_a[W-1] ^ op_b[W-1]) & (op_a[W-1] ^ ext[W-1])));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {c_q, p_q, a_q, z_q, s_q, o_q} <= '0;
    end else if (wr_en && op_ok) begin
      c_q <= c_n;
      p_q <= ~^result[7:0];
      a_q <= a_n;
      z_q <= (result == '0);
      s_q <= result[W-1];
      o_q <= o_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= (ctl_q & ~ctl_clr) | ctl_set;
  end

  assign flags = {4'b0, o_q, ctl_q, s_q, z_q, 1'b0, a_q, 1'b0, p_q, 1'b1, c_q};

  a_r8_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    flags[1] && flags[3] == 1'b0 && flags[5] == 1'b0 && flags[15:12] == 4'b0);

  a_r9_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_set == 3'b0 && ctl_clr == 3'b0) |=> $stable(flags[10:8]));

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_set != 3'b0) |=> ((flags[10:8] & $past(ctl_set)) == $past(ctl_set)));

  a_r8_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(flags[7:0]) && $stable(flags[OB])));

  a_r10_bad_op_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel > 3'd4) |=> ($stable(flags[7:0]) && $stable(flags[OB])));

  a_r3_logic_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op_sel >= 3'd2 && op_sel <= 3'd4) |=> (!flags[CB] && !flags[OB] && !flags[AB]));

  a_r5_zero_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op_ok) |=> (flags[ZB] == ($past(result) == '0) && flags[SB] == $past(result[W-1])));

  a_r7_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op_ok) |=> (flags[PB] == ($countones($past(result[7:0])) % 2 == 0)));

  a_r9_ctl_pos: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_clr[0] && !ctl_set[0]) |=> !flags[TB]);
endmodule

// File: tb/sim_flag_alu16.sv
module sim_flag_alu16;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic [2:0]  op_sel = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  ctl_set = '0, ctl_clr = '0;
  logic [15:0] result, flags;

  int checks = 0, errors = 0;
  logic [15:0] exp_flags;

  flag_alu16 u0 (.clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
                 .wr_en(wr_en), .ctl_set(ctl_set), .ctl_clr(ctl_clr),
                 .result(result), .flags(flags));

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [15:0] ref_result(logic [15:0] a, logic [15:0] b, logic [2:0] op);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [15:0] ref_flags(logic [15:0] prev, logic [15:0] a, logic [15:0] b,
                                            logic [2:0] op, logic we, logic [2:0] st, logic [2:0] cl);
    logic [15:0] f;
    logic [15:0] r;
    int sa, sb, sr;
    f = prev;
    r = ref_result(a, b, op);
    sa = $signed(a);
    sb = $signed(b);
    if (we && op <= 3'd4) begin
      f[0] = 1'b0; f[4] = 1'b0; f[11] = 1'b0;
      if (op == 3'd0) begin
        f[0] = (int'(a) + int'(b)) > 65535;
        sr = sa + sb;
        f[11] = (sr > 32767) || (sr < -32768);
        f[4] = (int'(a[3:0]) + int'(b[3:0])) > 15;
      end else if (op == 3'd1) begin
        f[0] = a < b;
        sr = sa - sb;
        f[11] = (sr > 32767) || (sr < -32768);
        f[4] = a[3:0] < b[3:0];
      end
      f[7] = r[15];
      f[6] = (r == 16'h0);
      f[2] = ($countones(r[7:0]) % 2) == 0;
    end
    f[10:8] = (f[10:8] & ~cl) | st;
    return f;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic [15:0] a, logic [15:0] b, logic [2:0] op,
                      logic we, logic [2:0] st, logic [2:0] cl);
    @(negedge clk);
    op_a = a; op_b = b; op_sel = op; wr_en = we; ctl_set = st; ctl_clr = cl;
    #1;
    chk({tag, " R2 result"}, result, ref_result(a, b, op));
    exp_flags = ref_flags(exp_flags, a, b, op, we, st, cl);
    @(negedge clk);
    chk({tag, " flags"}, flags, exp_flags);
    wr_en = 1'b0; ctl_set = '0; ctl_clr = '0;
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    exp_flags = 16'h0002;
    repeat (3) @(negedge clk);
    chk("R1 reset flags", flags, 16'h0002);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", flags, 16'h0002);

    step("R3 R5 R6 R7 add wrap", 16'hFFFF, 16'h0001, 3'd0, 1'b1, 3'b0, 3'b0);
    chk("R3 carry", {15'b0, flags[0]}, 16'h1);
    chk("R5 zero", {15'b0, flags[6]}, 16'h1);
    chk("R6 nibble carry", {15'b0, flags[4]}, 16'h1);
    chk("R7 parity even", {15'b0, flags[2]}, 16'h1);
    step("R4 add overflow", 16'h7FFF, 16'h0001, 3'd0, 1'b1, 3'b0, 3'b0);
    chk("R4 overflow", {15'b0, flags[11]}, 16'h1);
    chk("R5 sign", {15'b0, flags[7]}, 16'h1);
    step("R4 sub overflow", 16'h8000, 16'h0001, 3'd1, 1'b1, 3'b0, 3'b0);
    chk("R4 sub ov", {15'b0, flags[11]}, 16'h1);
    chk("R6 sub borrow", {15'b0, flags[4]}, 16'h1);
    step("R3 sub borrow", 16'h0005, 16'h0007, 3'd1, 1'b1, 3'b0, 3'b0);
    chk("R3 borrow", {15'b0, flags[0]}, 16'h1);
    step("R3 R4 R6 logic", 16'hF0F1, 16'h0F01, 3'd3, 1'b1, 3'b0, 3'b0);
    chk("R3 logic clears carry", {15'b0, flags[0]}, 16'h0);
    step("R7 parity odd", 16'h0001, 16'h0000, 3'd4, 1'b1, 3'b0, 3'b0);
    chk("R7 odd count", {15'b0, flags[2]}, 16'h0);
    step("R8 hold no write", 16'hFFFF, 16'h0001, 3'd0, 1'b0, 3'b0, 3'b0);
    step("R10 bad op 5", 16'h1234, 16'h1234, 3'd5, 1'b1, 3'b0, 3'b0);
    step("R10 bad op 7", 16'hFFFF, 16'hFFFF, 3'd7, 1'b1, 3'b0, 3'b0);
    step("R9 set all", 16'h0, 16'h0, 3'd2, 1'b0, 3'b111, 3'b0);
    chk("R9 ctl set", {13'b0, flags[10:8]}, 16'h7);
    step("R9 arith keeps ctl", 16'hFFFF, 16'h0001, 3'd0, 1'b1, 3'b0, 3'b0);
    step("R9 clear trap", 16'h0, 16'h0, 3'd2, 1'b0, 3'b0, 3'b001);
    step("R9 set wins", 16'h0, 16'h0, 3'd2, 1'b0, 3'b010, 3'b111);
    chk("R9 both strobes", {13'b0, flags[10:8]}, 16'h2);

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a, b;
      a = 16'($urandom);
      b = 16'($urandom);
      if (i % 7 == 0) b = a;
      step("R8 random", a, b, 3'($urandom_range(0, 7)), 1'($urandom),
           3'($urandom), 3'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule